// File: doc/BRIEF.md
# Composite Sandcastle Blanking Generator

This block builds the per-line three-level composite blanking waveform used by a display deflection path. It runs on a line-locked clock (nominally 864 clock periods per line) and restarts an internal line-position counter at every rising edge of the line sync input. From that position it derives a fixed colour-burst gate and a horizontal blanking gate, and optionally merges in a full-line vertical blanking component. The result is encoded as a 2-bit level code plus a burst-active flag for a downstream analog driver.

The horizontal blanking gate has two sources. With the select-enable control at 0 it simply tracks the external line flyback pulse. With it at 1 the gate is computed from three programmable fields (horizontal shift, blanking phase, blanking time) as a clock-count window relative to the sync edge. All control fields and the vertical blanking request are captured only at the sync edge, so a control update never alters a line already in progress.

Top module: `sandcastle_gen`

## Requirements
- R1: When the captured blanking-disable field is 1, `level` is never 01; the burst level is still produced.
- R2: When the captured select-enable is 0 and no vertical component applies, horizontal blanking is active at line position n exactly when `flyback` was high in the clock period before (position n-1).
- R3: When the captured select-enable is 1, the horizontal blanking window is 4*T+1 clock periods wide, T being the unsigned 6-bit blanking time.
- R4: Line position 0 is the clock period that follows the clock edge at which `line_sync` is first seen high; with select-enable 1 the window starts at position S + 4*P - 2*T + 43 (S signed 8-bit shift, P signed 6-bit phase), and any part of the window before position 0 is dropped.
- R5: The burst gate covers positions 36 to 89 (54 periods); there `level` is 10 and `burst_on` is 1, and `burst_on` is 0 elsewhere.
- R6: Where burst and blanking overlap the burst level 10 is output; blanking alone gives 01, neither gives 00.
- R7: With the captured vertical blanking request at 1 and the vertical mask field at 0, every position of the line is at least blanking level; with the mask at 1 only horizontal blanking appears.
- R8: Control fields and the vertical blanking request are sampled only at the sync rising edge; changes within a line take effect from the next line.
- R9: After reset and before the first sync edge `level` is 00 and `burst_on` is 0 (with `flyback` low); the line position saturates at its maximum when no sync arrives, so no gate is reopened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_sync | input | 1 | Line sync; rising edge marks position 0 |
| flyback | input | 1 | Line flyback pulse, horizontal blanking source when select-enable is 0 |
| vblank_req | input | 1 | Vertical blanking request, captured per line |
| blank_off | input | 1 | 1 disables all blanking levels |
| hb_sel_en | input | 1 | 1 selects the programmed horizontal window, 0 the flyback pulse |
| hb_time | input | 6 | Horizontal blanking time T, unsigned |
| hb_phase | input | 6 | Horizontal blanking phase P, signed |
| h_shift | input | 8 | Horizontal shift S, signed |
| vblank_mask | input | 1 | 1 suppresses the vertical blanking component |
| level | output | 2 | Level code: 00 low, 01 blanking, 10 burst |
| burst_on | output | 1 | Burst gate active |

## Verification
The bench builds the block with its default widths: a 10-bit line-position counter, 6-bit time and phase and an 8-bit shift. These small fields let it sweep every blanking time and every phase value, and step the shift across its full signed range including both extremes, so windows clipped before position 0, windows overlapping the burst and the widest window are all compared cycle by cycle against an arithmetic model. Flyback patterns, mid-line control changes and a line long enough to saturate the counter cover the remaining paths.

// File: rtl/sc_pkg.sv
// Shared types for the sandcastle blanking generator.
// Assumes a two-bit level code consumed by an external output driver.
package sc_pkg;
    typedef enum logic [1:0] {
        SC_LOW   = 2'b00,
        SC_BLANK = 2'b01,
        SC_BURST = 2'b10
    } sc_level_e;
endpackage

// File: rtl/sc_line_ctl.sv
// Line timing core: detects the sync rising edge, runs the line position
// counter and captures every control field at that edge.
// Assumes line_sync is synchronous to clk.
module sc_line_ctl #(
    parameter int CNT_W   = 10,
    parameter int TIME_W  = 6,
    parameter int PHASE_W = 6,
    parameter int SHIFT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_sync,
    input  logic               flyback,
    input  logic               vblank_req,
    input  logic               blank_off,
    input  logic               hb_sel_en,
    input  logic [TIME_W-1:0]  hb_time,
    input  logic [PHASE_W-1:0] hb_phase,
    input  logic [SHIFT_W-1:0] h_shift,
    input  logic               vblank_mask,
    output logic [CNT_W-1:0]   pos,
    output logic               fly_q,
    output logic               vreq_q,
    output logic               off_q,
    output logic               sel_q,
    output logic [TIME_W-1:0]  time_q,
    output logic [PHASE_W-1:0] phase_q,
    output logic [SHIFT_W-1:0] shift_q,
    output logic               mask_q
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic sync_q;
    logic sync_rise;

    assign sync_rise = line_sync & ~sync_q;

    // Remember the previous sync level and the flyback level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            fly_q  <= 1'b0;
        end else begin
            sync_q <= line_sync;
            fly_q  <= flyback;
        end
    end

    // Line position: restart at the sync edge, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= POS_MAX;
        else if (sync_rise)
            pos <= '0;
        else if (pos != POS_MAX)
            pos <= pos + 1'b1;
    end

    // Capture the control fields once per line at the sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vreq_q  <= 1'b0;
            off_q   <= 1'b0;
            sel_q   <= 1'b0;
            time_q  <= '0;
            phase_q <= '0;
            shift_q <= '0;
            mask_q  <= 1'b0;
        end else if (sync_rise) begin
            vreq_q  <= vblank_req;
            off_q   <= blank_off;
            sel_q   <= hb_sel_en;
            time_q  <= hb_time;
            phase_q <= hb_phase;
            shift_q <= h_shift;
            mask_q  <= vblank_mask;
        end
    end

    assert_pos_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> (pos == '0));

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_rise |=> ($stable(time_q) && $stable(phase_q) && $stable(shift_q)
                        && $stable(sel_q) && $stable(off_q) && $stable(vreq_q)
                        && $stable(mask_q)));

    assert_pos_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_rise && pos == POS_MAX) |=> (pos == POS_MAX));
endmodule

// File: rtl/sc_window.sv
// Signed position window: active while start <= pos < start + len.
// Assumes start + len fits in CALC_W signed bits.
module sc_window #(
    parameter int CNT_W  = 10,
    parameter int CALC_W = 13
) (
    input  logic [CNT_W-1:0]         pos,
    input  logic signed [CALC_W-1:0] start,
    input  logic signed [CALC_W-1:0] len,
    output logic                     active
);
    logic signed [CALC_W-1:0] pos_x;
    logic signed [CALC_W-1:0] stop;

    // Compare the zero-extended position against both window edges.
    always_comb begin
        pos_x  = $signed({{(CALC_W-CNT_W){1'b0}}, pos});
        stop   = start + len;
        active = (pos_x >= start) && (pos_x < stop);
    end
endmodule

// File: rtl/sc_level_mux.sv
// Merges burst, horizontal and vertical blanking into the level code.
// Assumes burst outranks blanking and the disable field removes blanking only.
module sc_level_mux
    import sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       burst,
    input  logic       hblank,
    input  logic       vblank,
    input  logic       off,
    output logic [1:0] level,
    output logic       burst_on
);
    sc_level_e lvl;

    // Priority select of the output level.
    always_comb begin
        if (burst)
            lvl = SC_BURST;
        else if ((hblank || vblank) && !off)
            lvl = SC_BLANK;
        else
            lvl = SC_LOW;
    end

    assign level    = lvl;
    assign burst_on = burst;

    assert_no_blank_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> (level != SC_BLANK));

    assert_burst_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_on |-> (level == SC_BURST));

    assert_vertical_full_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !off) |-> (level != SC_LOW));
endmodule

// File: rtl/sandcastle_gen.sv
// Composite sandcastle blanking generator top. Builds burst and horizontal
// blanking windows from the line position and merges an optional vertical
// component. Assumes CNT_W leaves room for the signed window arithmetic.
module sandcastle_gen #(
    parameter int CNT_W       = 10,
    parameter int TIME_W      = 6,
    parameter int PHASE_W     = 6,
    parameter int SHIFT_W     = 8,
    parameter int BURST_START = 36,
    parameter int BURST_LEN   = 54,
    parameter int HB_OFFSET   = 43
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_sync,
    input  logic               flyback,
    input  logic               vblank_req,
    input  logic               blank_off,
    input  logic               hb_sel_en,
    input  logic [TIME_W-1:0]  hb_time,
    input  logic [PHASE_W-1:0] hb_phase,
    input  logic [SHIFT_W-1:0] h_shift,
    input  logic               vblank_mask,
    output logic [1:0]         level,
    output logic               burst_on
);
    localparam int CALC_W = CNT_W + 3;

    logic [CNT_W-1:0]   pos;
    logic               fly_q, vreq_q, off_q, sel_q, mask_q;
    logic [TIME_W-1:0]  time_q;
    logic [PHASE_W-1:0] phase_q;
    logic [SHIFT_W-1:0] shift_q;

    logic signed [CALC_W-1:0] sh_x, ph_x, tm_x;
    logic signed [CALC_W-1:0] hb_start, hb_len;
    logic                     hb_win, burst_win, hblank;

    sc_line_ctl #(
        .CNT_W(CNT_W), .TIME_W(TIME_W), .PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .flyback(flyback),
        .vblank_req(vblank_req), .blank_off(blank_off), .hb_sel_en(hb_sel_en),
        .hb_time(hb_time), .hb_phase(hb_phase), .h_shift(h_shift),
        .vblank_mask(vblank_mask), .pos(pos), .fly_q(fly_q), .vreq_q(vreq_q),
        .off_q(off_q), .sel_q(sel_q), .time_q(time_q), .phase_q(phase_q),
        .shift_q(shift_q), .mask_q(mask_q)
    );

    // Programmed window: start = shift + 4*phase - 2*time + offset, width 4*time+1.
    always_comb begin
        sh_x     = $signed({{(CALC_W-SHIFT_W){shift_q[SHIFT_W-1]}}, shift_q});
        ph_x     = $signed({{(CALC_W-PHASE_W){phase_q[PHASE_W-1]}}, phase_q});
        tm_x     = $signed({{(CALC_W-TIME_W){1'b0}}, time_q});
        hb_start = sh_x + (ph_x <<< 2) - (tm_x <<< 1) + CALC_W'(HB_OFFSET);
        hb_len   = (tm_x <<< 2) + CALC_W'(1);
    end

    sc_window #(.CNT_W(CNT_W), .CALC_W(CALC_W)) u_hb_win (
        .pos(pos), .start(hb_start), .len(hb_len), .active(hb_win)
    );

    sc_window #(.CNT_W(CNT_W), .CALC_W(CALC_W)) u_burst_win (
        .pos(pos), .start(CALC_W'(BURST_START)), .len(CALC_W'(BURST_LEN)),
        .active(burst_win)
    );

    // Pick the horizontal blanking source.
    assign hblank = sel_q ? hb_win : fly_q;

    sc_level_mux u_mux (
        .clk(clk), .rst_n(rst_n), .burst(burst_win), .hblank(hblank),
        .vblank(vreq_q & ~mask_q), .off(off_q), .level(level), .burst_on(burst_on)
    );

    assert_flyback_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && !off_q && !burst_on && !(vreq_q && !mask_q)) |->
            (level == {1'b0, fly_q}));
endmodule

// File: tb/tb_sandcastle_gen.sv
module tb_sandcastle_gen;
    logic clk = 1'b0;
    logic rst_n, line_sync, flyback, vblank_req, blank_off, hb_sel_en, vblank_mask;
    logic [1:0] level;
    logic burst_on;

    int c_time, c_phase, c_shift;
    bit c_off, c_sel, c_vreq, c_mask;
    int e_time, e_phase, e_shift;
    bit e_off, e_sel, e_vreq, e_mask;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    assign blank_off   = c_off;
    assign hb_sel_en   = c_sel;
    assign vblank_req  = c_vreq;
    assign vblank_mask = c_mask;

    sandcastle_gen dut (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .flyback(flyback),
        .vblank_req(vblank_req), .blank_off(blank_off), .hb_sel_en(hb_sel_en),
        .hb_time(6'(c_time)), .hb_phase(6'(c_phase)), .h_shift(8'(c_shift)),
        .vblank_mask(vblank_mask), .level(level), .burst_on(burst_on)
    );

    function automatic logic [1:0] exp_lvl(int n, bit fprev);
        int s, w;
        bit b, h, v;
        s = e_shift + 4 * e_phase - 2 * e_time + 43;
        w = 4 * e_time + 1;
        b = (n >= 36) && (n < 90);
        h = e_sel ? ((n >= s) && (n < s + w)) : fprev;
        v = e_vreq && !e_mask;
        if (b) return 2'b10;
        if ((h || v) && !e_off) return 2'b01;
        return 2'b00;
    endfunction

    task automatic set_ctrl(bit off, bit sel, int t, int p, int s, bit vr, bit m);
        c_off = off; c_sel = sel; c_time = t; c_phase = p; c_shift = s;
        c_vreq = vr; c_mask = m;
    endtask

    // One line: sync pulse, then compare every position against the model.
    task automatic run_line(int len, int fa, int fb, bit mid, string tag);
        bit bad = 0;
        bit fprev = 0;
        logic [1:0] ex;
        @(negedge clk);
        line_sync = 1'b1;
        flyback = 1'b0;
        e_off = c_off; e_sel = c_sel; e_time = c_time; e_phase = c_phase;
        e_shift = c_shift; e_vreq = c_vreq; e_mask = c_mask;
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            if (n == 0) line_sync = 1'b0;
            ex = exp_lvl(n, fprev);
            if ((level !== ex) || (burst_on !== (ex == 2'b10))) begin
                if (!bad)
                    $display("FAIL %s pos=%0d level=%b burst=%b expected level=%b burst=%b",
                             tag, n, level, burst_on, ex, (ex == 2'b10));
                bad = 1;
            end
            fprev = (n >= fa) && (n < fb);
            flyback = fprev;
            if (mid && n == 200) begin
                c_off = !e_off; c_sel = !e_sel; c_time = (e_time + 17) % 64;
                c_phase = -e_phase - 1; c_shift = 50 - e_shift;
                c_vreq = !e_vreq; c_mask = !e_mask;
            end
        end
        flyback = 1'b0;
        checks++;
        if (bad) failures++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ptab[4] = '{-32, 31, 0, -5};
        int stab[4] = '{-128, 127, 0, 40};
        rst_n = 1'b0; line_sync = 1'b0; flyback = 1'b0;
        set_ctrl(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset state before any sync edge
        begin
            bit bad = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (level !== 2'b00 || burst_on !== 1'b0) begin
                    if (!bad) $display("FAIL R9 reset level=%b burst=%b expected level=00 burst=0",
                                       level, burst_on);
                    bad = 1;
                end
            end
            checks++;
            if (bad) failures++;
        end

        // R3 R4 R5 R6: every blanking time, with phase/shift extremes
        for (int t = 0; t < 64; t++) begin
            set_ctrl(0, 1, t, ptab[t % 4], stab[t % 4], 0, 0);
            run_line(440, 0, 0, 0, "R3_R4_time_sweep");
        end
        // R4: every phase value
        for (int p = -32; p < 32; p++) begin
            set_ctrl(0, 1, 20, p, -3, 0, 0);
            run_line(440, 0, 0, 0, "R4_phase_sweep");
        end
        // R4: shift across its signed range
        for (int s = -128; s < 128; s += 5) begin
            set_ctrl(0, 1, 7, 2, s, 0, 0);
            run_line(440, 0, 0, 0, "R4_shift_sweep");
        end
        set_ctrl(0, 1, 63, 31, 127, 0, 0);
        run_line(440, 0, 0, 0, "R3_widest_window");

        // R2 R6: flyback-driven blanking, incl. overlap with burst
        set_ctrl(0, 0, 40, 10, 10, 0, 0);
        run_line(440, 10, 50, 0, "R2_R6_flyback_overlap");
        run_line(440, 0, 1, 0, "R2_flyback_single");
        run_line(440, 100, 300, 0, "R2_flyback_long");
        run_line(440, 430, 439, 0, "R2_flyback_late");

        // R1: disable removes blanking, burst stays
        set_ctrl(1, 1, 63, 0, 0, 1, 0);
        run_line(440, 0, 0, 0, "R1_off_programmed");
        set_ctrl(1, 0, 0, 0, 0, 1, 0);
        run_line(440, 20, 200, 0, "R1_off_flyback");

        // R7: vertical component and its mask
        set_ctrl(0, 1, 5, 0, 0, 1, 0);
        run_line(440, 0, 0, 0, "R7_vertical_full_line");
        set_ctrl(0, 1, 5, 0, 0, 1, 1);
        run_line(440, 0, 0, 0, "R7_vertical_masked");
        set_ctrl(0, 0, 5, 0, 0, 1, 1);
        run_line(440, 150, 170, 0, "R7_masked_flyback");

        // R8: controls changed mid-line do not affect the running line
        set_ctrl(0, 1, 30, 4, 60, 0, 1);
        run_line(440, 0, 0, 1, "R8_midline_change_a");
        run_line(440, 0, 0, 0, "R8_next_line_uses_new");
        set_ctrl(1, 0, 3, -9, -20, 1, 0);
        run_line(440, 250, 320, 1, "R8_midline_change_b");

        // R9: long line, counter saturates, vertical blanking kept
        set_ctrl(0, 1, 10, 0, 0, 0, 0);
        run_line(1200, 0, 0, 0, "R9_saturate");
        set_ctrl(0, 1, 10, 0, 0, 1, 0);
        run_line(1200, 0, 0, 0, "R9_saturate_vertical");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule